// File: doc/BRIEF.md
# Power-Up Sequencing Supervisor

This block is the supervisory state machine that orders start-up and shutdown of a combined power-factor-correction (PFC) stage and a fixed-frequency half-bridge stage. It does not see analog quantities. It consumes comparator flags about the supply rail and the PFC feedback node, plus a strobe that marks the first PFC gate pulse. From these it decides when the high-voltage startup current source charges the supply capacitor, when the PFC stage may switch, and when the half-bridge may follow.

Internally the supervisor walks five states: charging, waiting for feedback, PFC only, running and feedback fault. The charging state sets the startup source and nothing else. Waiting for feedback has every output low. PFC only sets the PFC enable. Running sets both enables. Fault has every output low. The state register is updated on the clock, and the outputs are a pure decode of that register, so each output moves one clock after the flags that cause it are sampled. A parameter selects a binary or one-hot state register, and the choice does not change the port behaviour. The reset is asserted asynchronously and released through a short synchronizer.

Top module: `pwr_seq_ctrl`

## Requirements
- R1: In charging, `startup_src_on`=1 and both enables are 0. A sampled `supply_on`=1 (with `supply_off`=0) moves the block to waiting, where all three outputs are 0. Every other flag is ignored while charging.
- R2: In waiting, when `supply_off`=0, `supply_min_ok`=1 and `fb_uv_high`=1 are sampled together, `pfc_en` is 1 from the next cycle on and `hb_en` stays 0.
- R3: In PFC only, a sampled `pfc_pulse`=1 (with `supply_off`=0 and `fb_uv_low`=0) sets `hb_en` together with `pfc_en` from the next cycle on. `pfc_pulse` has no effect in charging, waiting or fault.
- R4: In waiting, a sampled `supply_min_ok`=0 (with `supply_off`=0) returns the block to charging. This refusal wins over `fb_uv_high`=1 in the same cycle.
- R5: A sampled `supply_off`=1 in any state leads, on the next cycle, to `startup_src_on`=1 with both enables 0. It takes priority over every other flag.
- R6: In PFC only or running, a sampled `fb_uv_low`=1 (with `supply_off`=0) drops both enables on the next cycle and leaves the startup source off. This fault takes priority over `pfc_pulse`.
- R7: From the fault state, only `fb_uv_high`=1 leaves the fault, and it leads to waiting rather than straight back to PFC only. A further qualifying cycle is then needed to re-enable the PFC stage.
- R8: While `rst_n`=0, `startup_src_on`=1 and both enables are 0. The block starts in charging once reset is released. `hb_en` is never 1 while `pfc_en` is 0.
- R9: The binary (`ONE_HOT`=0) and one-hot (`ONE_HOT`=1) register variants produce identical outputs for identical stimulus.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Supervisor clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously |
| supply_on | input | 1 | Supply is above its turn-on level |
| supply_min_ok | input | 1 | Supply is above its minimum enable level |
| supply_off | input | 1 | Supply is at or below its turn-off level |
| fb_uv_high | input | 1 | Feedback is above the undervoltage release threshold |
| fb_uv_low | input | 1 | Feedback is below the undervoltage trip threshold |
| pfc_pulse | input | 1 | A PFC gate pulse has been issued |
| startup_src_on | output | 1 | Turns on the high-voltage startup current source |
| pfc_en | output | 1 | Enables the PFC controller |
| hb_en | output | 1 | Enables the half-bridge controller |

## Verification
The bench first steers the block into each of the five states, using only the flag sequences the requirements define. In each state it then applies all 64 combinations of the six flags, which exposes every priority clash, such as turn-off against fault, sag against feedback release, and fault against the first pulse. Waiting and fault look the same at the ports, so every applied combination is followed by a probe cycle that asserts only feedback release and minimum supply. That probe separates a block that re-arms through waiting from one that jumps straight to PFC, and it reveals any hidden state left behind by an ignored flag. A one-hot copy runs alongside the binary one so that every comparison also checks that the two variants agree.

// File: rtl/pwr_seq_pkg.sv
package pwr_seq_pkg;

  localparam int unsigned NUM_STATES = 5;
  localparam int unsigned STATE_W    = $clog2(NUM_STATES);

  // Encoding order is used by the one-hot variant as a bit index.
  typedef enum logic [STATE_W-1:0] {
    ST_CHARGE   = 3'd0,
    ST_WAIT_FB  = 3'd1,
    ST_PFC_ONLY = 3'd2,
    ST_RUN      = 3'd3,
    ST_FAULT    = 3'd4
  } seq_state_e;

  typedef struct packed {
    logic supply_on;
    logic supply_min_ok;
    logic supply_off;
    logic fb_uv_high;
    logic fb_uv_low;
    logic pfc_pulse;
  } seq_flags_t;

  typedef struct packed {
    logic startup_src;
    logic pfc_en;
    logic hb_en;
  } seq_drive_t;

endpackage

// File: rtl/seq_rst_sync.sv
module seq_rst_sync #(
  parameter int unsigned STAGES = 2
) (
  input  logic clk,
  input  logic rst_n,
  output logic rst_n_sync
);

  localparam int unsigned SH_W = (STAGES < 2) ? 2 : STAGES;

  logic [SH_W-1:0] shift_q;

  // Assertion is immediate, release walks through SH_W flops.
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      shift_q <= '0;
    end else begin
      shift_q <= {shift_q[SH_W-2:0], 1'b1};
    end
  end

  assign rst_n_sync = shift_q[SH_W-1];

endmodule

// File: rtl/seq_next.sv
module seq_next
  import pwr_seq_pkg::*;
(
  input  seq_state_e cur_state,
  input  seq_flags_t flags,
  output seq_state_e nxt_state
);

  always_comb begin
    nxt_state = cur_state;
    if (flags.supply_off) begin
      // Turn-off outranks everything: back to charging.
      nxt_state = ST_CHARGE;
    end else begin
      case (cur_state)
        ST_CHARGE: begin
          if (flags.supply_on) nxt_state = ST_WAIT_FB;
        end
        ST_WAIT_FB: begin
          // Sag below minimum enable refuses start, even with feedback ready.
          if (!flags.supply_min_ok)  nxt_state = ST_CHARGE;
          else if (flags.fb_uv_high) nxt_state = ST_PFC_ONLY;
        end
        ST_PFC_ONLY: begin
          if (flags.fb_uv_low)      nxt_state = ST_FAULT;
          else if (flags.pfc_pulse) nxt_state = ST_RUN;
        end
        ST_RUN: begin
          if (flags.fb_uv_low) nxt_state = ST_FAULT;
        end
        ST_FAULT: begin
          // Recovery re-arms through the waiting state.
          if (flags.fb_uv_high) nxt_state = ST_WAIT_FB;
        end
        default: nxt_state = ST_CHARGE;
      endcase
    end
  end

endmodule

// File: rtl/seq_state_reg.sv
module seq_state_reg
  import pwr_seq_pkg::*;
#(
  parameter bit ONE_HOT = 1'b0
) (
  input  logic       clk,
  input  logic       rst_n,
  input  seq_state_e nxt_state,
  output seq_state_e cur_state
);

  logic upd_en;
  assign upd_en = (nxt_state != cur_state);

  generate
    if (ONE_HOT) begin : g_onehot
      logic [NUM_STATES-1:0] oh_q;
      logic [NUM_STATES-1:0] oh_d;

      always_comb begin
        oh_d = '0;
        oh_d[nxt_state] = 1'b1;
      end

      always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
          oh_q <= NUM_STATES'(1) << ST_CHARGE;
        end else if (upd_en) begin
          oh_q <= oh_d;
        end
      end

      always_comb begin
        cur_state = ST_CHARGE;
        for (int i = 0; i < NUM_STATES; i++) begin
          if (oh_q[i]) cur_state = seq_state_e'(STATE_W'(i));
        end
      end
    end else begin : g_binary
      seq_state_e st_q;

      always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
          st_q <= ST_CHARGE;
        end else if (upd_en) begin
          st_q <= nxt_state;
        end
      end

      assign cur_state = st_q;
    end
  endgenerate

endmodule

// File: rtl/seq_out_dec.sv
module seq_out_dec
  import pwr_seq_pkg::*;
(
  input  seq_state_e cur_state,
  output seq_drive_t drive
);

  always_comb begin
    drive = '0;
    case (cur_state)
      ST_CHARGE:   drive.startup_src = 1'b1;
      ST_WAIT_FB:  drive = '0;
      ST_PFC_ONLY: drive.pfc_en = 1'b1;
      ST_RUN: begin
        drive.pfc_en = 1'b1;
        drive.hb_en  = 1'b1;
      end
      ST_FAULT:    drive = '0;
      default:     drive.startup_src = 1'b1;
    endcase
  end

endmodule

// File: rtl/pwr_seq_ctrl.sv
module pwr_seq_ctrl
  import pwr_seq_pkg::*;
#(
  parameter bit          ONE_HOT     = 1'b0,
  parameter int unsigned SYNC_STAGES = 2
) (
  input  logic clk,
  input  logic rst_n,
  input  logic supply_on,
  input  logic supply_min_ok,
  input  logic supply_off,
  input  logic fb_uv_high,
  input  logic fb_uv_low,
  input  logic pfc_pulse,
  output logic startup_src_on,
  output logic pfc_en,
  output logic hb_en
);

  logic       rst_n_sync;
  seq_flags_t flags;
  seq_state_e cur_state;
  seq_state_e nxt_state;
  seq_drive_t drive;

  assign flags.supply_on     = supply_on;
  assign flags.supply_min_ok = supply_min_ok;
  assign flags.supply_off    = supply_off;
  assign flags.fb_uv_high    = fb_uv_high;
  assign flags.fb_uv_low     = fb_uv_low;
  assign flags.pfc_pulse     = pfc_pulse;

  seq_rst_sync #(.STAGES(SYNC_STAGES)) u_rst_sync (
    .clk        (clk),
    .rst_n      (rst_n),
    .rst_n_sync (rst_n_sync)
  );

  seq_next u_next (
    .cur_state (cur_state),
    .flags     (flags),
    .nxt_state (nxt_state)
  );

  seq_state_reg #(.ONE_HOT(ONE_HOT)) u_state (
    .clk       (clk),
    .rst_n     (rst_n_sync),
    .nxt_state (nxt_state),
    .cur_state (cur_state)
  );

  seq_out_dec u_dec (
    .cur_state (cur_state),
    .drive     (drive)
  );

  assign startup_src_on = drive.startup_src;
  assign pfc_en         = drive.pfc_en;
  assign hb_en          = drive.hb_en;

endmodule

// File: rtl/pwr_seq_chk.sv
module pwr_seq_chk (
  input logic clk,
  input logic rst_n,
  input logic supply_on,
  input logic supply_min_ok,
  input logic supply_off,
  input logic fb_uv_high,
  input logic fb_uv_low,
  input logic pfc_pulse,
  input logic startup_src_on,
  input logic pfc_en,
  input logic hb_en
);

  // Startup source is released only by the turn-on flag.
  assert_src_release_R1: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(startup_src_on) |-> $past(supply_on) && !$past(supply_off));

  // PFC enable rises only after feedback release with adequate supply.
  assert_pfc_start_R2: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(pfc_en) |-> $past(fb_uv_high) && $past(supply_min_ok) && !$past(supply_off));

  // Half-bridge rises only on a pulse seen while PFC was enabled.
  assert_hb_after_pulse_R3: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(hb_en) |-> $past(pfc_pulse) && $past(pfc_en));

  // Startup source comes back only on turn-off or a minimum-enable sag.
  assert_src_return_R4: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(startup_src_on) |-> $past(supply_off) || !$past(supply_min_ok));

  assert_turn_off_R5: assert property (@(posedge clk) disable iff (!rst_n)
    supply_off |=> startup_src_on && !pfc_en && !hb_en);

  assert_fb_fault_R6: assert property (@(posedge clk) disable iff (!rst_n)
    (pfc_en && fb_uv_low && !supply_off) |=> !pfc_en && !hb_en && !startup_src_on);

  assert_hb_needs_pfc_R8: assert property (@(posedge clk) disable iff (!rst_n)
    hb_en |-> pfc_en);

  assert_src_excl_R1: assert property (@(posedge clk) disable iff (!rst_n)
    startup_src_on |-> !pfc_en && !hb_en);

endmodule

bind pwr_seq_ctrl pwr_seq_chk u_chk (
  .clk            (clk),
  .rst_n          (rst_n),
  .supply_on      (supply_on),
  .supply_min_ok  (supply_min_ok),
  .supply_off     (supply_off),
  .fb_uv_high     (fb_uv_high),
  .fb_uv_low      (fb_uv_low),
  .pfc_pulse      (pfc_pulse),
  .startup_src_on (startup_src_on),
  .pfc_en         (pfc_en),
  .hb_en          (hb_en)
);

// File: tb/pwr_seq_ctrl_bench.sv
module pwr_seq_ctrl_bench;

  localparam int CLK_PERIOD = 10;
  localparam int WATCHDOG_CYCLES = 150000;

  // Bench-side state codes: 0 charge, 1 wait, 2 pfc only, 3 run, 4 fault.
  // Flag vector: [0] supply_on [1] supply_min_ok [2] supply_off
  //              [3] fb_uv_high [4] fb_uv_low [5] pfc_pulse
  localparam logic [5:0] V_IDLE  = 6'b000000;
  localparam logic [5:0] V_TO_WT = 6'b000011;
  localparam logic [5:0] V_TO_PF = 6'b001010;
  localparam logic [5:0] V_TO_RN = 6'b101010;
  localparam logic [5:0] V_TO_FT = 6'b010010;
  localparam logic [5:0] V_PROBE = 6'b001010;

  logic clk;
  logic rst_n;
  logic [5:0] fv;
  logic src_b, pfc_b, hb_b;
  logic src_o, pfc_o, hb_o;
  int n_tests;
  int n_fail;
  int mstate;

  initial clk = 1'b0;
  always #(CLK_PERIOD/2) clk = ~clk;

  pwr_seq_ctrl #(.ONE_HOT(1'b0)) u_pwr_seq_ctrl (
    .clk (clk), .rst_n (rst_n),
    .supply_on (fv[0]), .supply_min_ok (fv[1]), .supply_off (fv[2]),
    .fb_uv_high (fv[3]), .fb_uv_low (fv[4]), .pfc_pulse (fv[5]),
    .startup_src_on (src_b), .pfc_en (pfc_b), .hb_en (hb_b)
  );

  pwr_seq_ctrl #(.ONE_HOT(1'b1)) u_pwr_seq_ctrl_oh (
    .clk (clk), .rst_n (rst_n),
    .supply_on (fv[0]), .supply_min_ok (fv[1]), .supply_off (fv[2]),
    .fb_uv_high (fv[3]), .fb_uv_low (fv[4]), .pfc_pulse (fv[5]),
    .startup_src_on (src_o), .pfc_en (pfc_o), .hb_en (hb_o)
  );

  function automatic int model_next(input int s, input logic [5:0] v);
    if (v[2]) return 0;
    case (s)
      0: return v[0] ? 1 : 0;
      1: return !v[1] ? 0 : (v[3] ? 2 : 1);
      2: return v[4] ? 4 : (v[5] ? 3 : 2);
      3: return v[4] ? 4 : 3;
      default: return v[3] ? 1 : 4;
    endcase
  endfunction

  function automatic string model_tag(input int s, input logic [5:0] v);
    if (v[2]) return "R5";
    case (s)
      0: return "R1";
      1: return !v[1] ? "R4" : "R2";
      2: return v[4] ? "R6" : "R3";
      3: return v[4] ? "R6" : "R3";
      default: return "R7";
    endcase
  endfunction

  function automatic logic [2:0] model_out(input int s);
    return {s == 0, (s == 2) || (s == 3), s == 3};
  endfunction

  task automatic check_out(input string tag, input logic [2:0] exp);
    n_tests++;
    if ({src_b, pfc_b, hb_b} !== exp) begin
      n_fail++;
      $display("FAIL %s state=%0d flags=%b got=%b expected=%b",
               tag, mstate, fv, {src_b, pfc_b, hb_b}, exp);
    end
    n_tests++;
    if ({src_o, pfc_o, hb_o} !== {src_b, pfc_b, hb_b}) begin
      n_fail++;
      $display("FAIL R9 one-hot got=%b expected=%b",
               {src_o, pfc_o, hb_o}, {src_b, pfc_b, hb_b});
    end
  endtask

  // Drive a flag vector at 1 time unit after an edge, sample after the next edge.
  task automatic step(input logic [5:0] v);
    fv = v;
    @(posedge clk);
    #1;
    mstate = model_next(mstate, v);
  endtask

  task automatic do_reset();
    rst_n = 1'b0;
    fv = V_IDLE;
    #2;
    mstate = 0;
    check_out("R8", 3'b100);
    @(posedge clk);
    #1;
    rst_n = 1'b1;
    for (int k = 0; k < 4; k++) step(V_IDLE);
    check_out("R8", 3'b100);
  endtask

  task automatic goto_state(input int target);
    if (target >= 1) step(V_TO_WT);
    if (target >= 2) step(V_TO_PF);
    if (target >= 3) step(V_TO_RN);
    if (target >= 4) step(V_TO_FT);
  endtask

  initial begin
    n_tests = 0;
    n_fail  = 0;
    mstate  = 0;
    rst_n   = 1'b0;
    fv      = V_IDLE;
    for (int st = 0; st < 5; st++) begin
      for (int v = 0; v < 64; v++) begin
        string tg;
        do_reset();
        goto_state(st);
        check_out("R8", model_out(st));
        tg = model_tag(mstate, 6'(v));
        step(6'(v));
        check_out(tg, model_out(mstate));
        tg = model_tag(mstate, V_PROBE);
        step(V_PROBE);
        check_out(tg, model_out(mstate));
      end
    end
    // R7: fault recovery needs a second qualifying cycle.
    do_reset();
    goto_state(4);
    step(6'b001000);
    check_out("R7", 3'b000);
    step(V_PROBE);
    check_out("R7", 3'b010);
    $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
    $finish;
  end

  initial begin
    repeat (WATCHDOG_CYCLES) @(posedge clk);
    n_tests++;
    n_fail++;
    $display("FAIL watchdog expired got=running expected=done");
    $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
    $finish;
  end

endmodule